// File: doc/BRIEF.md
# Presence-Vector Snoop Filter

This block is a tag-only coherence directory that sits beside a shared cache level. For every line address it tracks, it keeps one presence bit per private core. A set bit means that core may hold a copy of the line. No line data is stored. Cores report three kinds of events: a read miss, a request for ownership, and a clean-eviction notice. The directory updates its presence vectors from these events. For an ownership request it returns an invalidation mask that names only the other possible holders, so it never needs to broadcast.

The directory is set-associative with least-recently-used replacement. A miss that finds its set full displaces the oldest entry. Every core marked in that entry must then drop its copy, so the block emits a back-invalidation pulse that carries the victim's line address and presence vector. Each request is looked up and applied in a single clock. Its results appear on registered outputs in the following cycle, and a new request may be presented on every cycle.

Top module: `sf_presence_dir`

## Requirements
- R1: After reset every output is zero and no line is tracked, so the first read of any address reports a miss.
- R2: A read (req_type_i = 2'b00) that hits adds the requester's bit to the entry's presence vector and reports resp_hit_o = 1.
- R3: An ownership request (req_type_i = 2'b01) that hits drives inv_mask_o with the stored vector minus the requester's bit. inv_valid_o is 1 exactly when that mask is non-zero. Afterwards the vector holds only the requester's bit.
- R4: A read or ownership miss allocates an entry holding only the requester's bit. When the set has an unused way, no back-invalidation is issued.
- R5: A read or ownership miss to a set with all ways in use evicts one entry. It pulses bwd_inv_valid_o together with that entry's presence vector on bwd_inv_mask_o and its line address on bwd_inv_addr_o.
- R6: A clean-eviction notice (req_type_i = 2'b10) clears the requester's bit. An entry whose vector becomes empty is released, so a later read of that address misses.
- R7: A clean-eviction notice for an untracked address, or from a core whose bit is clear, raises no invalidation output and leaves the directory unchanged.
- R8: req_type_i = 2'b11 is ignored. No output is raised and no entry changes.
- R9: Outputs for a request are valid in the cycle after it is accepted and last one cycle. resp_valid_o is 1 for every request of type 0 to 2, and requests may arrive back to back.
- R10: The entry evicted is the least recently used one. Read and ownership hits refresh an entry's recency, but clean-eviction notices do not.
- R11: The line address is split so that req_addr_i[SET_W-1:0] selects the set and the remaining upper bits form the tag. bwd_inv_addr_o is rebuilt in the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_type_i | input | 2 | 00 read, 01 ownership, 10 clean eviction, 11 ignored |
| req_core_i | input | CORE_W (2) | Requesting core index |
| req_addr_i | input | ADDR_W (20) | Line address: set in low bits, tag above |
| resp_valid_o | output | 1 | Lookup result valid |
| resp_hit_o | output | 1 | Address was tracked at lookup |
| inv_valid_o | output | 1 | Targeted invalidation for an ownership request |
| inv_mask_o | output | NUM_CORES (4) | Cores to invalidate |
| bwd_inv_valid_o | output | 1 | Capacity eviction back-invalidation pulse |
| bwd_inv_mask_o | output | NUM_CORES (4) | Cores holding the evicted line |
| bwd_inv_addr_o | output | ADDR_W (20) | Evicted line address |

## Verification
The hardest condition to reach from the ports is a capacity eviction whose victim differs from plain allocation order. That case needs a full set, a recency refresh on one old entry, and a clean-eviction notice that must not refresh another. The bench fills one set with eight tags, re-reads the first tag, sends a non-holder eviction notice to the second, and then misses. The back-invalidation must name the second tag. The bench also sweeps all fifteen non-empty presence vectors against all four requesters for ownership masks. It then runs a long random stream over two sets and twelve tags, where evictions, releases and reallocations interleave. All outputs are compared against a timestamp-based reference model.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    REQ_READ = 2'b00,
    REQ_OWN  = 2'b01,
    REQ_DROP = 2'b10,
    REQ_RSVD = 2'b11
  } req_kind_e;
endpackage

// File: rtl/sf_tag_match.sv
module sf_tag_match #(
  parameter int NUM_WAYS = 8,
  parameter int TAG_W    = 15,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]             way_valid_i,
  input  logic [NUM_WAYS-1:0][TAG_W-1:0]  way_tag_i,
  input  logic [TAG_W-1:0]                tag_i,
  output logic                            hit_o,
  output logic [WAY_W-1:0]                hit_way_o
);
  logic [NUM_WAYS-1:0] eq;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign eq[w] = way_valid_i[w] && (way_tag_i[w] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (eq[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/sf_victim_pick.sv
module sf_victim_pick #(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]             way_valid_i,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0]  way_age_i,
  output logic                            free_any_o,
  output logic [WAY_W-1:0]                pick_way_o
);
  logic [NUM_WAYS-1:0] oldest;
  logic [WAY_W-1:0]    free_way, lru_way;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_old
    assign oldest[w] = (way_age_i[w] == WAY_W'(NUM_WAYS - 1));
  end

  always_comb begin
    free_way = '0;
    lru_way  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!way_valid_i[w]) free_way = WAY_W'(w);
      if (oldest[w])       lru_way  = WAY_W'(w);
    end
  end

  assign free_any_o = ~&way_valid_i;
  assign pick_way_o = free_any_o ? free_way : lru_way;
endmodule

// File: rtl/sf_lru_ages.sv
module sf_lru_ages #(
  parameter int NUM_SETS = 32,
  parameter int NUM_WAYS = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [SET_W-1:0]                set_i,
  input  logic                            touch_i,
  input  logic [WAY_W-1:0]                touch_way_i,
  output logic [NUM_WAYS-1:0][WAY_W-1:0]  ages_o
);
  // ages per set form a permutation of 0..NUM_WAYS-1; 0 = most recent
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAY_W-1:0] ref_age;

  assign ages_o  = age_q[set_i];
  assign ref_age = age_q[set_i][touch_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)      age_q[set_i][w] <= '0;
        else if (age_q[set_i][w] < ref_age) age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
      end
    end
  end

  logic [NUM_WAYS-1:0] is_max;
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_max
    assign is_max[w] = (ages_o[w] == WAY_W'(NUM_WAYS - 1));
  end

  p_lru_single_oldest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_max) == 1);
endmodule

// File: rtl/sf_presence_dir.sv
module sf_presence_dir #(
  parameter int NUM_CORES = 4,
  parameter int NUM_SETS  = 32,
  parameter int NUM_WAYS  = 8,
  parameter int ADDR_W    = 20,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int WAY_W    = $clog2(NUM_WAYS),
  localparam int TAG_W    = ADDR_W - SET_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_type_i,
  input  logic [CORE_W-1:0]    req_core_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 resp_valid_o,
  output logic                 resp_hit_o,
  output logic                 inv_valid_o,
  output logic [NUM_CORES-1:0] inv_mask_o,
  output logic                 bwd_inv_valid_o,
  output logic [NUM_CORES-1:0] bwd_inv_mask_o,
  output logic [ADDR_W-1:0]    bwd_inv_addr_o
);
  import sf_pkg::*;

  logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]     tag_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][NUM_CORES-1:0] vec_q;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]                val_q;

  req_kind_e             kind;
  logic [SET_W-1:0]      set_idx;
  logic [TAG_W-1:0]      req_tag;
  logic [NUM_CORES-1:0]  req_bit;
  logic                  hit;
  logic [WAY_W-1:0]      hit_way, pick_way, wr_way;
  logic                  free_any;
  logic [NUM_WAYS-1:0][WAY_W-1:0] ages;
  logic                  do_read, do_own, do_drop, alloc, victim_live, touch;
  logic [NUM_CORES-1:0]  cur_vec, victim_vec, others, wr_vec;
  logic [TAG_W-1:0]      victim_tag;
  logic                  wr_en, wr_val;

  assign kind    = req_kind_e'(req_type_i);
  assign set_idx = req_addr_i[SET_W-1:0];
  assign req_tag = req_addr_i[ADDR_W-1:SET_W];
  assign req_bit = NUM_CORES'(1) << req_core_i;

  sf_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_match (
    .way_valid_i (val_q[set_idx]),
    .way_tag_i   (tag_q[set_idx]),
    .tag_i       (req_tag),
    .hit_o       (hit),
    .hit_way_o   (hit_way)
  );

  sf_lru_ages #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_idx),
    .touch_i     (touch),
    .touch_way_i (wr_way),
    .ages_o      (ages)
  );

  sf_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .way_valid_i (val_q[set_idx]),
    .way_age_i   (ages),
    .free_any_o  (free_any),
    .pick_way_o  (pick_way)
  );

  assign do_read     = req_valid_i && (kind == REQ_READ);
  assign do_own      = req_valid_i && (kind == REQ_OWN);
  assign do_drop     = req_valid_i && (kind == REQ_DROP);
  assign alloc       = (do_read || do_own) && !hit;
  assign victim_live = alloc && !free_any;
  assign touch       = do_read || do_own;
  assign wr_way      = hit ? hit_way : pick_way;

  assign cur_vec    = vec_q[set_idx][hit_way];
  assign others     = cur_vec & ~req_bit;
  assign victim_vec = vec_q[set_idx][pick_way];
  assign victim_tag = tag_q[set_idx][pick_way];

  always_comb begin
    wr_en  = 1'b0;
    wr_val = 1'b1;
    wr_vec = req_bit;
    if (alloc || do_own) begin
      wr_en = 1'b1;
    end else if (do_read) begin
      wr_en  = 1'b1;
      wr_vec = cur_vec | req_bit;
    end else if (do_drop && hit) begin
      wr_en  = 1'b1;
      wr_vec = others;
      wr_val = |others;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      vec_q[set_idx][wr_way] <= wr_vec;
      if (alloc) tag_q[set_idx][wr_way] <= req_tag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (wr_en) begin
      val_q[set_idx][wr_way] <= wr_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o    <= 1'b0;
      resp_hit_o      <= 1'b0;
      inv_valid_o     <= 1'b0;
      inv_mask_o      <= '0;
      bwd_inv_valid_o <= 1'b0;
      bwd_inv_mask_o  <= '0;
      bwd_inv_addr_o  <= '0;
    end else begin
      resp_valid_o    <= do_read || do_own || do_drop;
      resp_hit_o      <= (do_read || do_own || do_drop) && hit;
      inv_valid_o     <= do_own && hit && (|others);
      inv_mask_o      <= (do_own && hit) ? others : '0;
      bwd_inv_valid_o <= victim_live;
      bwd_inv_mask_o  <= victim_live ? victim_vec : '0;
      bwd_inv_addr_o  <= victim_live ? {victim_tag, set_idx} : '0;
    end
  end

  p_tracked_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && hit) |-> (cur_vec != '0));

  p_victim_has_holder_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bwd_inv_valid_o |-> (bwd_inv_mask_o != '0));

  p_bwd_on_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bwd_inv_valid_o |-> (resp_valid_o && !resp_hit_o));

  p_inv_only_own_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && kind != REQ_OWN) |=> !inv_valid_o);

  p_inv_skips_requester_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_own |=> ((inv_mask_o & $past(req_bit)) == '0));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || kind == REQ_RSVD) |=> !(resp_valid_o || inv_valid_o || bwd_inv_valid_o));
endmodule

// File: tb/sf_presence_dir_tb.sv
module sf_presence_dir_tb;
  localparam int NUM_CORES = 4;
  localparam int NUM_SETS  = 32;
  localparam int NUM_WAYS  = 8;
  localparam int ADDR_W    = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [1:0] req_type_i = '0;
  logic [1:0] req_core_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic resp_valid_o, resp_hit_o, inv_valid_o, bwd_inv_valid_o;
  logic [NUM_CORES-1:0] inv_mask_o, bwd_inv_mask_o;
  logic [ADDR_W-1:0] bwd_inv_addr_o;

  always #5 clk_i = ~clk_i;

  sf_presence_dir #(.NUM_CORES(NUM_CORES), .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS),
                    .ADDR_W(ADDR_W)) u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_type_i, .req_core_i, .req_addr_i,
    .resp_valid_o, .resp_hit_o, .inv_valid_o, .inv_mask_o,
    .bwd_inv_valid_o, .bwd_inv_mask_o, .bwd_inv_addr_o
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int m_tag [NUM_SETS][NUM_WAYS];
  int m_vec [NUM_SETS][NUM_WAYS];
  bit m_val [NUM_SETS][NUM_WAYS];
  int m_stamp [NUM_SETS][NUM_WAYS];
  int now = 0;
  int last_bwd_addr;

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // request at negedge; results checked at next negedge (one register stage)
  task automatic issue(int kind, int core, int s, int t);
    int hw, pw, bit_c;
    int e_resp, e_hit, e_iv, e_im, e_bv, e_bm, e_ba;
    req_valid_i = 1'b1;
    req_type_i  = 2'(kind);
    req_core_i  = 2'(core);
    req_addr_i  = ADDR_W'(t * NUM_SETS + s);
    bit_c = 1 << core;
    hw = -1;
    for (int w = 0; w < NUM_WAYS; w++) if (m_val[s][w] && m_tag[s][w] == t) hw = w;
    e_resp = (kind != 3); e_hit = (kind != 3) && (hw >= 0);
    e_iv = 0; e_im = 0; e_bv = 0; e_bm = 0; e_ba = 0;
    if (kind == 0 || kind == 1) begin
      now++;
      if (hw >= 0) begin
        if (kind == 1) begin
          e_im = m_vec[s][hw] & ~bit_c; e_iv = (e_im != 0);
          m_vec[s][hw] = bit_c;
        end else m_vec[s][hw] |= bit_c;
        m_stamp[s][hw] = now;
      end else begin
        pw = -1;
        for (int w = NUM_WAYS - 1; w >= 0; w--) if (!m_val[s][w]) pw = w;
        if (pw < 0) begin
          pw = 0;
          for (int w = 1; w < NUM_WAYS; w++) if (m_stamp[s][w] < m_stamp[s][pw]) pw = w;
          e_bv = 1; e_bm = m_vec[s][pw]; e_ba = m_tag[s][pw] * NUM_SETS + s;
        end
        m_val[s][pw] = 1; m_tag[s][pw] = t; m_vec[s][pw] = bit_c; m_stamp[s][pw] = now;
      end
    end else if (kind == 2 && hw >= 0) begin
      m_vec[s][hw] &= ~bit_c;
      if (m_vec[s][hw] == 0) m_val[s][hw] = 0;
    end
    @(negedge clk_i);
    chk("R9 resp_valid", int'(resp_valid_o), e_resp);
    chk("R2 resp_hit", int'(resp_hit_o), e_hit);
    chk("R3 inv_valid", int'(inv_valid_o), e_iv);
    chk("R3 inv_mask", int'(inv_mask_o), e_im);
    chk("R5 bwd_valid", int'(bwd_inv_valid_o), e_bv);
    chk("R5 bwd_mask", int'(bwd_inv_mask_o), e_bm);
    chk("R11 bwd_addr", int'(bwd_inv_addr_o), e_ba);
    last_bwd_addr = int'(bwd_inv_addr_o);
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R9 idle", int'({resp_valid_o, inv_valid_o, bwd_inv_valid_o}), 0);
  endtask

  initial begin
    for (int s = 0; s < NUM_SETS; s++)
      for (int w = 0; w < NUM_WAYS; w++) begin
        m_val[s][w] = 0; m_vec[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
      end
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 reset outputs", int'({resp_valid_o, resp_hit_o, inv_valid_o, inv_mask_o,
        bwd_inv_valid_o, bwd_inv_mask_o, bwd_inv_addr_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    issue(0, 0, 2, 7);                 // R1/R4 first read misses, no bwd
    chk("R1 first miss", int'(resp_hit_o), 0);
    issue(0, 1, 2, 7);                 // R2 sharers
    issue(0, 2, 2, 7);
    issue(1, 3, 2, 7);                 // R3 mask = 0111
    chk("R3 own mask", int'(inv_mask_o), 4'b0111);
    issue(0, 0, 2, 7);
    issue(1, 0, 2, 7);                 // R3 mask = 1000
    chk("R3 own mask2", int'(inv_mask_o), 4'b1000);
    idle();

    // R3 exhaustive over vectors and requesters
    for (int v = 1; v < 16; v++)
      for (int c = 0; c < 4; c++) begin
        for (int k = 0; k < 4; k++) if (v[k]) issue(0, k, 5, 100 + v * 4 + c);
        issue(1, c, 5, 100 + v * 4 + c);
        chk("R3 sweep", int'(inv_mask_o), v & ~(1 << c));
        issue(2, c, 5, 100 + v * 4 + c);   // R6 releases
        issue(0, c, 5, 100 + v * 4 + c);
        chk("R6 released miss", int'(resp_hit_o), 0);
        issue(2, c, 5, 100 + v * 4 + c);
      end
    idle();

    // R10: fill set 3, refresh tag 0, non-holder drop on tag 1 (R7), then miss
    for (int t = 0; t < NUM_WAYS; t++) issue(0, t % 4, 3, t);
    issue(0, 2, 3, 0);
    issue(2, 3, 3, 1);                 // core 3 does not hold tag 1
    chk("R7 nonholder drop", int'({inv_valid_o, bwd_inv_valid_o}), 0);
    issue(2, 1, 3, 99);                // untracked address
    chk("R7 untracked drop", int'(resp_hit_o), 0);
    issue(0, 0, 3, 50);
    chk("R10 lru victim addr", last_bwd_addr, 1 * NUM_SETS + 3);
    chk("R5 victim pulse", int'(bwd_inv_valid_o), 1);
    issue(0, 1, 3, 50);                // back-to-back hit
    chk("R5 pulse one cycle", int'(bwd_inv_valid_o), 0);
    // R6/R4: empty an entry, reallocate without back-invalidation
    issue(2, 2, 3, 2);
    issue(0, 3, 3, 2);
    chk("R4 free way used", int'(bwd_inv_valid_o), 0);
    // R8: reserved type ignored
    issue(3, 0, 3, 2);
    chk("R8 reserved quiet", int'({resp_valid_o, inv_valid_o, bwd_inv_valid_o}), 0);
    issue(1, 0, 3, 2);
    chk("R8 state kept", int'(inv_mask_o), 4'b1000);
    idle();

    // random stream over two sets and twelve tags
    for (int i = 0; i < 4000; i++)
      issue(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 11)));
    idle();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule